// File: doc/BRIEF.md
# Multi-Mode 8-bit PWM Timer

This block is an 8-bit timer/counter that advances once for every clock cycle on which its `tick` enable is high. A 3-bit mode input selects one of four counting shapes:

- a free-running counter;
- a counter that clears after reaching a programmable limit;
- a single-slope PWM;
- a dual-slope (phase-correct) PWM.

The counting ceiling (TOP) is either the all-ones value or the value held in compare register A.

Two compare registers are written through a shared data bus. In the PWM shapes each register is double-buffered, and the new value moves to the active register only at a point in the count that depends on the mode. Compare register B drives the waveform pin under a 2-bit output code. The block raises three sticky flags:

- overflow;
- compare-A match;
- compare-B match.

Each flag stays set until it is cleared through its own clear input.

A typical user sets the mode and output code, loads the compare values, and then gates `tick` from a prescaler. The block's outputs are the waveform pin, the three flags and the live count.

Top module: `pwm_timer8`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `count` is 0x00, all three flags are 0 and `wave_b` is 0.
- R2: On a cycle with `tick` low, the count, the counting direction, the flags' set sources and the pin do not change.
- R3: The mode input selects the counting shape and TOP as follows:
  - Modes 0, 4 and 6 count 0x00 to 0xFF and wrap, with TOP equal to 0xFF.
  - Mode 2 counts up and returns to 0x00 on the tick after the count equals TOP, where TOP is the active compare A.
  - Mode 3 counts like mode 2, with TOP equal to 0xFF.
  - Mode 7 counts like mode 2, with TOP equal to the active compare A.
- R4: Modes 1 (TOP=0xFF) and 5 (TOP=active compare A) count up to TOP and then down to 0x00. Each endpoint value is held for exactly one tick before the direction reverses.
- R5: Compare-register writes reach the active register at different points depending on the mode:
  - In modes 0, 2, 4 and 6, a write reaches the active register at the next clock edge.
  - In modes 1 and 5, a write goes to a shadow register and moves to the active register on the tick at which the count equals TOP while counting up.
  - In modes 3 and 7, the shadow moves to the active register on the tick at which the count wraps from TOP to 0x00.
- R6: `ovf_flag` sets on a tick at which the count changes, as follows:
  - In modes 0, 2, 3, 4 and 6, on a tick at which the count equals 0xFF.
  - In mode 7, on a tick at which the count equals TOP.
  - In modes 1 and 5, on a tick at which the count equals 0x00 while counting down.
- R7: `mata_flag` and `matb_flag` set on a tick at which the count equals the active compare A or B. All three flags stay set until their clear input is high for a cycle, and a new set event in that same cycle wins over the clear.
- R8: In modes 1 and 5, with compare B not equal to TOP:
  - `com_b`=10 clears the pin on a B match while counting up and sets it on a B match while counting down.
  - `com_b`=11 does the reverse.
- R9: In modes 1 and 5, when compare B equals TOP and `com_b[1]` is 1, B matches do not move the pin. Instead, on the tick at TOP the pin is set for `com_b`=10 and cleared for `com_b`=11.
- R10: In modes 3 and 7, `com_b`=10 sets the pin on the wrap tick and clears it on a B match, and `com_b`=11 does the reverse. When both events fall on the same tick, the wrap action wins.
- R11: In modes 0, 2, 4 and 6, a B match has the following effect on the pin:
  - `com_b`=01 toggles it.
  - `com_b`=10 clears it.
  - `com_b`=11 sets it.
- R12: `com_b`=00 drives `wave_b` low without changing the internal pin state. In modes 1, 3, 5 and 7, `com_b`=01 leaves the pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable for this cycle |
| mode | input | 3 | Waveform mode select |
| com_b | input | 2 | Compare-B output code |
| wr_a | input | 1 | Write `wdata` to compare A |
| wr_b | input | 1 | Write `wdata` to compare B |
| wdata | input | 8 | Compare write data |
| clr_ovf | input | 1 | Clear overflow flag |
| clr_mata | input | 1 | Clear compare-A match flag |
| clr_matb | input | 1 | Clear compare-B match flag |
| count | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| mata_flag | output | 1 | Sticky compare-A match flag |
| matb_flag | output | 1 | Sticky compare-B match flag |
| wave_b | output | 1 | Waveform output pin |

## Verification
Directed sequences cover four cases:
- a CTC run with a small limit, which shows the clear-after-TOP rule;
- a stretch with `tick` held low;
- a dual-slope run in which compare A is rewritten mid-ramp, which shows whether the new TOP is deferred to the next TOP crossing rather than taking effect immediately;
- the equal-to-TOP case of compare B.

Long random runs then change the mode, the output code and the write data, and they throttle `tick` at random. Small compare values are favoured, so matches, TOP crossings, shadow updates and coincident set/clear events occur often. Together these runs separate the three update points, the three overflow points and the direction-dependent pin actions.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  typedef enum logic [1:0] {SH_FREE, SH_CTC, SH_FAST, SH_DUAL} shape_e;

  function automatic shape_e shape_of(input logic [2:0] m);
    case (m)
      3'd1, 3'd5: return SH_DUAL;
      3'd2:       return SH_CTC;
      3'd3, 3'd7: return SH_FAST;
      default:    return SH_FREE;
    endcase
  endfunction

  function automatic logic top_from_a(input logic [2:0] m);
    return (m == 3'd2) || (m == 3'd5) || (m == 3'd7);
  endfunction

  function automatic logic writes_direct(input shape_e s);
    return (s == SH_FREE) || (s == SH_CTC);
  endfunction
endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter
  import pwmt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  shape_e        shape,
  input  logic [CW-1:0] top_val,
  output logic [CW-1:0] cnt_q,
  output logic          up_q,
  output logic          at_top,
  output logic          at_max,
  output logic          at_bot
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_n;
  logic          up_n;

  function automatic logic [CW-1:0] dual_step(input logic [CW-1:0] c,
                                              input logic up,
                                              input logic [CW-1:0] t);
    if (up) return (c == t) ? ((t == '0) ? '0 : t - ONE) : c + ONE;
    return (c == '0) ? ONE : c - ONE;
  endfunction

  assign at_top = tick && (cnt_q == top_val) && (shape != SH_DUAL || up_q);
  assign at_max = tick && (cnt_q == CMAX);
  assign at_bot = tick && (shape == SH_DUAL) && !up_q && (cnt_q == '0);

  always_comb begin
    cnt_n = cnt_q;
    up_n  = 1'b1;
    case (shape)
      SH_DUAL: begin
        cnt_n = dual_step(cnt_q, up_q, top_val);
        if (up_q) up_n = (cnt_q != top_val);
        else      up_n = (cnt_q == '0);
      end
      SH_CTC, SH_FAST: cnt_n = (cnt_q == top_val) ? '0 : cnt_q + ONE;
      default:         cnt_n = cnt_q + ONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick) begin
      cnt_q <= cnt_n;
      up_q  <= up_n;
    end
  end

  // R2
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q) && $stable(up_q));
  // R3
  clear_after_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (shape == SH_CTC || shape == SH_FAST) && cnt_q == top_val |=> cnt_q == '0);
  // R3
  free_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && shape == SH_FREE |=> cnt_q == $past(cnt_q) + ONE);
  // R4
  dual_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && shape == SH_DUAL && up_q && cnt_q == top_val && top_val != '0
    |=> !up_q && cnt_q == $past(top_val) - ONE);
endmodule

// File: rtl/pwmt_cmpbuf.sv
module pwmt_cmpbuf #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          direct,
  input  logic          upd_evt,
  output logic [CW-1:0] act_q
);
  logic [CW-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      if (wr) shadow_q <= wdata;
      if (direct) begin
        if (wr) act_q <= wdata;
      end else if (upd_evt) begin
        act_q <= shadow_q;
      end
    end
  end

  // R5
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && direct |=> act_q == $past(wdata));
  // R5
  buffered_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !direct && !upd_evt |=> $stable(act_q));
endmodule

// File: rtl/pwmt_wave.sv
module pwmt_wave
  import pwmt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  shape_e        shape,
  input  logic [1:0]    com,
  input  logic [CW-1:0] cnt,
  input  logic          up,
  input  logic [CW-1:0] ocrb,
  input  logic [CW-1:0] top_val,
  input  logic          at_top,
  output logic          pin_q,
  output logic          wave
);
  logic match_b;
  logic pin_n;

  assign match_b = tick && (cnt == ocrb);

  function automatic logic pin_step(input shape_e s, input logic [1:0] c,
                                    input logic p, input logic m,
                                    input logic t, input logic u,
                                    input logic eq_top);
    logic r;
    r = p;
    case (s)
      SH_DUAL:
        if (c[1]) begin
          if (eq_top) begin
            if (t) r = ~c[0];
          end else if (m) begin
            r = u ? c[0] : ~c[0];
          end
        end
      SH_FAST:
        if (c[1]) begin
          if (t)      r = ~c[0];
          else if (m) r = c[0];
        end
      default:
        if (m) begin
          case (c)
            2'b01:   r = ~p;
            2'b10:   r = 1'b0;
            2'b11:   r = 1'b1;
            default: r = p;
          endcase
        end
    endcase
    return r;
  endfunction

  assign pin_n = pin_step(shape, com, pin_q, match_b, at_top, up, ocrb == top_val);
  assign wave  = (com == 2'b00) ? 1'b0 : pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_n;
  end

  // R8
  dual_up_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_b && shape == SH_DUAL && com == 2'b10 && ocrb != top_val && up |=> !pin_q);
  // R9
  dual_top_case_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_top && shape == SH_DUAL && com == 2'b11 && ocrb == top_val |=> !pin_q);
  // R10
  fast_wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_top && shape == SH_FAST && com == 2'b10 |=> pin_q);
  // R12
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    com == 2'b00 |-> !wave);
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwmt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [2:0]    mode,
  input  logic [1:0]    com_b,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic [CW-1:0] wdata,
  input  logic          clr_ovf,
  input  logic          clr_mata,
  input  logic          clr_matb,
  output logic [CW-1:0] count,
  output logic          ovf_flag,
  output logic          mata_flag,
  output logic          matb_flag,
  output logic          wave_b
);
  localparam logic [CW-1:0] CMAX = '1;

  shape_e        shape;
  logic [CW-1:0] ocra_act, ocrb_act, top_val, cnt;
  logic          up, at_top, at_max, at_bot, direct;
  logic          ovf_evt, match_a, match_b, pin;

  assign shape   = shape_of(mode);
  assign direct  = writes_direct(shape);
  assign top_val = top_from_a(mode) ? ocra_act : CMAX;

  pwmt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .shape(shape), .top_val(top_val),
    .cnt_q(cnt), .up_q(up), .at_top(at_top), .at_max(at_max), .at_bot(at_bot));

  pwmt_cmpbuf #(.CW(CW)) u_buf_a (
    .clk(clk), .rst_n(rst_n), .wr(wr_a), .wdata(wdata), .direct(direct),
    .upd_evt(at_top), .act_q(ocra_act));

  pwmt_cmpbuf #(.CW(CW)) u_buf_b (
    .clk(clk), .rst_n(rst_n), .wr(wr_b), .wdata(wdata), .direct(direct),
    .upd_evt(at_top), .act_q(ocrb_act));

  pwmt_wave #(.CW(CW)) u_wave (
    .clk(clk), .rst_n(rst_n), .tick(tick), .shape(shape), .com(com_b),
    .cnt(cnt), .up(up), .ocrb(ocrb_act), .top_val(top_val), .at_top(at_top),
    .pin_q(pin), .wave(wave_b));

  assign ovf_evt = (shape == SH_DUAL) ? at_bot : ((mode == 3'd7) ? at_top : at_max);
  assign match_a = tick && (cnt == ocra_act);
  assign match_b = tick && (cnt == ocrb_act);
  assign count   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag  <= 1'b0;
      mata_flag <= 1'b0;
      matb_flag <= 1'b0;
    end else begin
      ovf_flag  <= ovf_evt | (ovf_flag & ~clr_ovf);
      mata_flag <= match_a | (mata_flag & ~clr_mata);
      matb_flag <= match_b | (matb_flag & ~clr_matb);
    end
  end

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);
  // R7
  mata_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_mata && !match_a |=> !mata_flag);
  // R7
  matb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_b |=> matb_flag);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !clr_ovf |=> ovf_flag);
  // R11
  free_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_b && direct && com_b == 2'b11 |=> pin);
endmodule

// File: tb/pwm_timer8_tb_top.sv
`timescale 1ns/1ps
module pwm_timer8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [1:0] com_b = 2'b00;
  logic       wr_a = 1'b0, wr_b = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       clr_ovf = 1'b0, clr_mata = 1'b0, clr_matb = 1'b0;
  logic [7:0] count;
  logic       ovf_flag, mata_flag, matb_flag, wave_b;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_cnt, m_a, m_b, m_sa, m_sb;
  logic       m_up, m_ovf, m_fa, m_fb, m_pin;

  always #5 clk = ~clk;

  pwm_timer8 dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .com_b(com_b),
    .wr_a(wr_a), .wr_b(wr_b), .wdata(wdata), .clr_ovf(clr_ovf),
    .clr_mata(clr_mata), .clr_matb(clr_matb), .count(count),
    .ovf_flag(ovf_flag), .mata_flag(mata_flag), .matb_flag(matb_flag),
    .wave_b(wave_b));

  function automatic bit is_dual(input logic [2:0] m);
    return m == 3'd1 || m == 3'd5;
  endfunction
  function automatic bit is_fast(input logic [2:0] m);
    return m == 3'd3 || m == 3'd7;
  endfunction
  function automatic logic [7:0] top_for(input logic [2:0] m, input logic [7:0] a);
    return (m == 3'd2 || m == 3'd5 || m == 3'd7) ? a : 8'hFF;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [7:0] t;
    bit at_top, ovf_e, ma, mb, direct;
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_a = 0; m_b = 0; m_sa = 0; m_sb = 0;
      m_ovf = 0; m_fa = 0; m_fb = 0; m_pin = 0;
      return;
    end
    t      = top_for(mode, m_a);
    direct = !is_dual(mode) && !is_fast(mode);
    at_top = tick && m_cnt == t && (!is_dual(mode) || m_up);
    ma     = tick && m_cnt == m_a;
    mb     = tick && m_cnt == m_b;
    if (is_dual(mode))     ovf_e = tick && !m_up && m_cnt == 0;
    else if (mode == 3'd7) ovf_e = at_top;
    else                   ovf_e = tick && m_cnt == 8'hFF;
    // pin
    if (is_dual(mode)) begin
      if (com_b[1]) begin
        if (m_b == t) begin
          if (at_top) m_pin = (com_b == 2'b10);
        end else if (mb) begin
          m_pin = m_up ? (com_b == 2'b11) : (com_b == 2'b10);
        end
      end
    end else if (is_fast(mode)) begin
      if (com_b[1]) begin
        if (at_top)  m_pin = (com_b == 2'b10);
        else if (mb) m_pin = (com_b == 2'b11);
      end
    end else if (mb) begin
      if (com_b == 2'b01)      m_pin = ~m_pin;
      else if (com_b == 2'b10) m_pin = 0;
      else if (com_b == 2'b11) m_pin = 1;
    end
    // counter
    if (tick) begin
      if (is_dual(mode)) begin
        if (m_up) begin
          if (m_cnt == t) begin m_up = 0; m_cnt = (t == 0) ? 8'd0 : t - 8'd1; end
          else m_cnt = m_cnt + 8'd1;
        end else begin
          if (m_cnt == 0) begin m_up = 1; m_cnt = 8'd1; end
          else m_cnt = m_cnt - 8'd1;
        end
      end else begin
        m_up = 1;
        if (mode != 3'd0 && mode != 3'd4 && mode != 3'd6 && m_cnt == t) m_cnt = 0;
        else m_cnt = m_cnt + 8'd1;
      end
    end
    // compare registers
    if (direct) begin
      if (wr_a) m_a = wdata;
      if (wr_b) m_b = wdata;
    end else if (at_top) begin
      m_a = m_sa;
      m_b = m_sb;
    end
    if (wr_a) m_sa = wdata;
    if (wr_b) m_sb = wdata;
    // flags
    m_ovf = ovf_e || (m_ovf && !clr_ovf);
    m_fa  = ma || (m_fa && !clr_mata);
    m_fb  = mb || (m_fb && !clr_matb);
  endtask

  task automatic compare_all();
    string wt;
    if (com_b == 2'b00)                       wt = "R12";
    else if (is_dual(mode) && m_b == top_for(mode, m_a)) wt = "R9";
    else if (is_dual(mode))                   wt = "R8";
    else if (is_fast(mode))                   wt = "R10";
    else                                      wt = "R11";
    check(is_dual(mode) ? "R4" : "R3", "count", count, m_cnt);
    check("R6", "ovf_flag", ovf_flag, m_ovf);
    check("R7", "mata_flag", mata_flag, m_fa);
    check("R7", "matb_flag", matb_flag, m_fb);
    check(wt, "wave_b", wave_b, (com_b == 2'b00) ? 0 : m_pin);
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 0; tick = 0; wr_a = 0; wr_b = 0;
    clr_ovf = 0; clr_mata = 0; clr_matb = 0;
    cycle(); cycle();
    check("R1", "reset count", count, 0);
    check("R1", "reset flags", {ovf_flag, mata_flag, matb_flag}, 0);
    check("R1", "reset wave", wave_b, 0);
    rst_n = 1;
    cycle();
    check("R1", "count after reset", count, 0);
  endtask

  initial begin
    logic [7:0] held;
    int mx;
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();

    // R2: no tick, no motion
    mode = 3'd0; com_b = 2'b00; tick = 1;
    for (int i = 0; i < 7; i++) cycle();
    held = count; tick = 0;
    for (int i = 0; i < 5; i++) cycle();
    check("R2", "count held without tick", count, held);

    // R3: CTC with limit 3
    do_reset();
    mode = 3'd2; wr_a = 1; wdata = 8'd3; cycle(); wr_a = 0; tick = 1;
    for (int i = 0; i < 8; i++) begin
      cycle();
      check("R3", "ctc sequence", count, (i + 1) % 4);
    end

    // R5: dual-slope TOP change deferred to next TOP
    do_reset();
    mode = 3'd0; wr_a = 1; wdata = 8'd10; cycle(); wr_a = 0;
    mode = 3'd5; tick = 1;
    for (int i = 0; i < 3; i++) cycle();
    wr_a = 1; wdata = 8'd4; cycle(); wr_a = 0;
    mx = 0;
    for (int i = 0; i < 20; i++) begin cycle(); if (count > mx) mx = count; end
    check("R5", "old TOP kept until TOP", mx, 10);
    check("R4", "count after turnaround", count, 4);
    mx = 0;
    for (int i = 0; i < 20; i++) begin cycle(); if (count > mx) mx = count; end
    check("R5", "new TOP after TOP", mx, 4);

    // R9: compare B equal to TOP in dual slope
    com_b = 2'b10; wr_b = 1; wdata = 8'd4;
    cycle(); wr_b = 0;
    for (int i = 0; i < 24; i++) cycle();
    check("R9", "pin high with B at TOP, code 10", wave_b, 1);

    // random phase
    do_reset();
    for (int i = 0; i < 12000; i++) begin
      if (i % 300 == 0) begin
        mode  = 3'($urandom % 8);
        com_b = 2'($urandom % 4);
      end
      tick  = ($urandom % 4) != 0;
      wr_a  = ($urandom % 40) == 0;
      wr_b  = ($urandom % 25) == 0;
      wdata = ($urandom % 3 == 0) ? 8'($urandom) : 8'(4 + $urandom % 20);
      clr_ovf  = ($urandom % 16) == 0;
      clr_mata = ($urandom % 16) == 0;
      clr_matb = ($urandom % 16) == 0;
      cycle();
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule